// File: doc/BRIEF.md
# Add/Subtract ALU with Condition Flags

A purely combinational arithmetic and logic unit for a processor datapath. Two operands and a 4-bit operation code come in. The unit returns a result word together with three flags: a zero flag, a signed-overflow flag and an unsigned carry flag. The operations are bitwise AND, bitwise OR, addition, subtraction and a signed set-if-less comparison. The operation code comes from a separate decoder that is not part of this block.

A single ripple chain of identical full-adder slices serves both addition and subtraction. For subtraction, every B bit passes through an XOR with the subtract select, and that same select drives the carry into bit 0, so the chain computes A + ~B + 1. Signed overflow is taken only from the top slice: the carry into the most significant bit XOR the carry out of it. The comparison reuses the subtraction and corrects the sign of the difference with the overflow, so it gives the right answer even when the difference overflows. The zero flag after a subtraction serves as an equality test for conditional branches.

The unit has no clock and no state. Its outputs follow its inputs after combinational delay. The operand width is a parameter.

Top module: `addsub_alu`

## Requirements
- R1: Code 4'b0000 returns op_a AND op_b, and code 4'b0001 returns op_a OR op_b, bit for bit.
- R2: Code 4'b0010 returns (op_a + op_b) mod 2^W. carry_flag is the carry out of the most significant bit.
- R3: Code 4'b0110 returns (op_a - op_b) mod 2^W. carry_flag is 1 exactly when op_a >= op_b taken as unsigned numbers, which is the raw carry out of A + ~B + 1.
- R4: For every defined code, zero_flag is 1 exactly when the result is all zeros. A subtraction of equal operands therefore asserts zero_flag.
- R5: For add and subtract, ovf_flag is 1 exactly when the true signed (two's complement) result lies outside the range [-2^(W-1), 2^(W-1)-1].
- R6: Code 4'b0111 returns 1 in bit 0 and zeros in all other bits when op_a < op_b as signed numbers, and all zeros otherwise. This holds when op_a - op_b overflows.
- R7: For codes 4'b0000, 4'b0001 and 4'b0111, ovf_flag and carry_flag are both 0.
- R8: Any code other than the five above returns a zero result, and zero_flag, ovf_flag and carry_flag are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| ctrl | input | 4 | Operation code |
| result | output | W | Operation result |
| zero_flag | output | 1 | Result is all zeros (defined codes only) |
| ovf_flag | output | 1 | Signed overflow of add or subtract |
| carry_flag | output | 1 | Carry out of the top slice for add or subtract |

## Verification
The bench builds the unit twice. The first build uses W = 4, so every pair of operands can be applied with every one of the 16 operation codes. That sweep reaches every overflow corner, every carry and borrow case, every comparison that crosses the sign boundary, and every unused code. The second build uses the default W = 32 and applies directed extreme values: the most negative and most positive numbers, all ones, and equal operands. These show that the ripple chain and the overflow taken from the top slice scale correctly to the full width.

// File: rtl/addsub_alu_pkg.sv
package addsub_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111
  } alu_code_e;
endpackage

// File: rtl/addsub_fa_slice.sv
module addsub_fa_slice (
  input  logic x_i,
  input  logic y_i,
  input  logic cin_i,
  output logic s_o,
  output logic cout_o
);
  assign s_o    = x_i ^ y_i ^ cin_i;
  assign cout_o = (x_i & y_i) | (cin_i & (x_i ^ y_i));
endmodule

// File: rtl/addsub_chain.sv
module addsub_chain #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         carry_msb_o
);
  logic [W:0]   c;
  logic [W-1:0] b_eff;

  assign c[0] = sub_i;

  for (genvar k = 0; k < W; k++) begin : g_slice
    assign b_eff[k] = b_i[k] ^ sub_i;
    addsub_fa_slice u_fa (
      .x_i   (a_i[k]),
      .y_i   (b_eff[k]),
      .cin_i (c[k]),
      .s_o   (sum_o[k]),
      .cout_o(c[k+1])
    );
  end

  assign carry_o     = c[W];
  assign carry_msb_o = c[W-1];

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i})) begin
      if (sub_i)
        AST_SUB_NO_BORROW: assert (carry_o == (a_i >= b_i)); // R3
      else
        AST_ADD_CARRY: assert ({carry_o, sum_o} == {1'b0, a_i} + {1'b0, b_i}); // R2
    end
  end
endmodule

// File: rtl/addsub_alu.sv
module addsub_alu
  import addsub_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   ctrl,
  output logic [W-1:0] result,
  output logic         zero_flag,
  output logic         ovf_flag,
  output logic         carry_flag
);
  localparam int MSB = W - 1;

  logic [W-1:0] sum;
  logic         c_out, c_into_msb, ovf_raw, less, sub_sel, known;

  assign sub_sel = (ctrl == OP_SUB) || (ctrl == OP_SLT);

  addsub_chain #(.W(W)) u_chain (
    .a_i        (op_a),
    .b_i        (op_b),
    .sub_i      (sub_sel),
    .sum_o      (sum),
    .carry_o    (c_out),
    .carry_msb_o(c_into_msb)
  );

  assign ovf_raw = c_into_msb ^ c_out;
  assign less    = sum[MSB] ^ ovf_raw;

  always_comb begin
    result     = '0;
    ovf_flag   = 1'b0;
    carry_flag = 1'b0;
    known      = 1'b1;
    case (ctrl)
      OP_AND: result = op_a & op_b;
      OP_OR:  result = op_a | op_b;
      OP_ADD, OP_SUB: begin
        result     = sum;
        ovf_flag   = ovf_raw;
        carry_flag = c_out;
      end
      OP_SLT: result = {{(W-1){1'b0}}, less};
      default: known = 1'b0;
    endcase
  end

  assign zero_flag = known && (result == '0);

  always_comb begin
    if (!$isunknown({op_a, op_b, ctrl})) begin
      if (ctrl == OP_ADD || ctrl == OP_SUB)
        AST_OVF_BY_SIGN: assert (ovf_flag == ((op_a[MSB] == (op_b[MSB] ^ sub_sel))
                                  && (result[MSB] != op_a[MSB]))); // R5
      if (ctrl == OP_SLT)
        AST_SLT_SHAPE: assert (result[W-1:1] == '0 &&
                               result[0] == ($signed(op_a) < $signed(op_b))); // R6
      if (ctrl == OP_AND || ctrl == OP_OR || ctrl == OP_SLT)
        AST_QUIET_FLAGS: assert (!ovf_flag && !carry_flag); // R7
      if (ctrl == OP_SUB && op_a == op_b)
        AST_EQUAL_ZERO: assert (zero_flag); // R4
      if (!(ctrl inside {OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT}))
        AST_UNUSED_CODE: assert (result == '0 && !zero_flag && !ovf_flag && !carry_flag); // R8
    end
  end
endmodule

// File: tb/addsub_alu_bench.sv
module addsub_alu_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [3:0]  a4, b4, c4, r4;
  logic        z4, v4, k4;
  logic [31:0] a32, b32, r32;
  logic [3:0]  c32;
  logic        z32, v32, k32;

  addsub_alu #(.W(4)) u_addsub_alu (
    .op_a(a4), .op_b(b4), .ctrl(c4), .result(r4),
    .zero_flag(z4), .ovf_flag(v4), .carry_flag(k4));

  addsub_alu #(.W(32)) u_addsub_alu_wide (
    .op_a(a32), .op_b(b32), .ctrl(c32), .result(r32),
    .zero_flag(z32), .ovf_flag(v32), .carry_flag(k32));

  function automatic string req_of(int code);
    case (code)
      0, 1:    return "R1";
      2:       return "R2";
      6:       return "R3";
      7:       return "R6";
      default: return "R8";
    endcase
  endfunction

  // Reference model for any width up to 32
  task automatic model(input int w, input longint ua, input longint ub, input int code,
                       output longint res, output bit z, output bit v, output bit k);
    longint m = (longint'(1) << w);
    longint sa = (ua >= m/2) ? ua - m : ua;
    longint sb = (ub >= m/2) ? ub - m : ub;
    longint t;
    bit valid = 1'b1;
    res = 0; v = 0; k = 0;
    case (code)
      0: res = ua & ub;
      1: res = ua | ub;
      2: begin
        res = (ua + ub) % m; k = (ua + ub) >= m;
        t = sa + sb; v = (t < -m/2) || (t > m/2 - 1);
      end
      6: begin
        res = (ua - ub + m) % m; k = ua >= ub;
        t = sa - sb; v = (t < -m/2) || (t > m/2 - 1);
      end
      7: res = (sa < sb) ? 1 : 0;
      default: valid = 1'b0;
    endcase
    z = valid && (res == 0);
  endtask

  task automatic check(input string req, input longint got, input longint exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wide_case(input logic [31:0] a, input logic [31:0] b, input int code);
    longint er; bit ez, ev, ek;
    a32 = a; b32 = b; c32 = code[3:0];
    @(negedge clk);
    model(32, longint'(a), longint'(b), code, er, ez, ev, ek);
    check(req_of(code), {r32, z32, v32, k32}, {er[31:0], ez, ev, ek}, "wide result/z/v/c");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    longint er; bit ez, ev, ek;
    // Startup state: AND of zeros gives zero result with zero flag (R1, R4)
    a4 = 0; b4 = 0; c4 = 0; a32 = 0; b32 = 0; c32 = 0;
    @(negedge clk);
    check("R4", {r4, z4, v4, k4}, {4'h0, 1'b1, 1'b0, 1'b0}, "initial AND zero");

    // Exhaustive sweep at W=4: R1 R2 R3 R4 R5 R6 R7 R8
    for (int code = 0; code < 16; code++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          a4 = a[3:0]; b4 = b[3:0]; c4 = code[3:0];
          #5;
          model(4, a, b, code, er, ez, ev, ek);
          check(req_of(code), r4, er[3:0], "result");
          check("R4", z4, ez, "zero_flag");
          check((code == 2 || code == 6) ? "R5" : "R7", v4, ev, "ovf_flag");
          check((code == 2 || code == 6) ? "R3" : "R7", k4, ek, "carry_flag");
          #5;
        end

    // Directed 32-bit corners
    wide_case(32'h7FFF_FFFF, 32'h0000_0001, 2); // R5 positive overflow
    wide_case(32'h8000_0000, 32'h8000_0000, 2); // R5 negative overflow, R2 carry
    wide_case(32'hFFFF_FFFF, 32'h0000_0001, 2); // R2 carry, R4 zero
    wide_case(32'h8000_0000, 32'h0000_0001, 6); // R5 subtract overflow
    wide_case(32'h1234_5678, 32'h1234_5678, 6); // R4 equality
    wide_case(32'h0000_0001, 32'h0000_0002, 6); // R3 borrow
    wide_case(32'h8000_0000, 32'h7FFF_FFFF, 7); // R6 less despite overflow
    wide_case(32'h7FFF_FFFF, 32'h8000_0000, 7); // R6 not less
    wide_case(32'hF0F0_A5A5, 32'h0FF0_5AA5, 0); // R1 AND
    wide_case(32'hF0F0_A5A5, 32'h0FF0_5AA5, 1); // R1 OR
    wide_case(32'hFFFF_FFFF, 32'hFFFF_FFFF, 15); // R8 unused code
    wide_case(32'h0000_0000, 32'h0000_0000, 3);  // R8 unused with zero operands

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule